// File: doc/BRIEF.md
# Precise Pipeline Exception Tracker

This block keeps exceptions precise in a five-stage in-order integer pipeline whose stages are fetch, decode, execute, memory and writeback. It holds one slot for each stage. A slot carries a valid bit, the instruction address and an eight-bit fault vector. Each of the first four stages has fault inputs. A fault input sets bits in the vector of the instruction that currently occupies that stage. The vector then travels with the instruction. Nothing acts on a fault when it is detected.

While an instruction's vector is non-zero, its memory write in the memory stage and its register write in writeback are suppressed. When the instruction sits in writeback, the block decides its fate. A clean instruction retires and pulses `retire` with its address. A faulted instruction pulses `exc_taken` with a cause code and its address as the restart point. In that same cycle every younger instruction is discarded, so faults are serviced in the order a non-overlapped machine would meet them. A stall freezes every slot. While the stall lasts, fault inputs keep being OR-ed into the held vectors.

Top module: `precise_exc_tracker`

## Requirements
- R1: After reset every slot is empty. With no fetch, `retire`, `exc_taken`, `rf_we` and `mem_we` stay low whatever the request inputs are.
- R2: A clean instruction accepted with `fetch_valid` in cycle t (no stall) sits in writeback in cycle t+5. In that cycle it pulses `retire` with `retire_pc` equal to its address and passes `rf_we_req` through to `rf_we`.
- R3: Fault bits, in priority order with cause codes: `if_flt[0]` fetch page fault = 1, `if_flt[1]` fetch protection = 2, `if_flt[2]` fetch misaligned = 3, `id_illegal` = 4, `ex_arith` = 5, `mem_flt[0]` data page fault = 6, `mem_flt[1]` data protection = 7, `mem_flt[2]` data misaligned = 8. A fault raised while the instruction is in that stage is reported at writeback with that code.
- R4: When several bits of one instruction's vector are set, the lowest code among them is reported. This holds both inside a stage and across stages.
- R5: An older instruction's fault is reported before a younger instruction's fault, even when the younger one's fault was raised in an earlier cycle.
- R6: In the cycle `exc_taken` pulses, all younger instructions are discarded. None of them later retires or reports.
- R7: `mem_we` is low when the memory-stage instruction has any fault bit set, including one raised in the same cycle. It is also low while writeback holds a faulted instruction. `rf_we` is low for a faulted instruction in writeback.
- R8: While `stall` is high, all slots hold, no report is made, and fault inputs are accumulated into the held vectors. The held report appears in the first cycle the stall is released.
- R9: Fault inputs raised against an empty slot are ignored and never produce a report.
- R10: `exc_taken` lasts exactly one cycle and gives `exc_pc` equal to the faulting instruction's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Holds all slots in place |
| fetch_valid | input | 1 | A new instruction enters the fetch slot |
| fetch_pc | input | PCW | Address of the new instruction |
| if_flt | input | 3 | Fetch faults: page, protection, misaligned |
| id_illegal | input | 1 | Undefined opcode in decode |
| ex_arith | input | 1 | Arithmetic fault in execute |
| mem_flt | input | 3 | Data faults: page, protection, misaligned |
| rf_we_req | input | 1 | Register write request from writeback |
| mem_we_req | input | 1 | Memory write request from the memory stage |
| rf_we | output | 1 | Gated register write enable |
| mem_we | output | 1 | Gated memory write enable |
| retire | output | 1 | Clean instruction completes |
| retire_pc | output | PCW | Address of the retiring instruction |
| exc_taken | output | 1 | One-cycle exception report |
| exc_cause | output | 4 | Cause code, 0 when none |
| exc_pc | output | PCW | Restart address |

## Verification
A table sends one instruction at a time through the pipeline with faults of every single kind and with pairs of faults in one stage. This tells apart the bit positions, the cause codes and the priority inside a stage. Sequences of two or three back-to-back instructions, with faults raised on the younger one first, show whether the report follows program order rather than detection time. They also show that the flush covers younger work and that the memory write is killed by an older fault. Stalls placed on the fetch slot and on writeback tell apart holding a slot, accumulating into it, and deferring a report. A run of faults against an empty pipeline checks that bubbles stay silent.

// File: rtl/precise_exc_tracker.sv
module precise_exc_tracker #(
  parameter int PCW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stall,
  input  logic           fetch_valid,
  input  logic [PCW-1:0] fetch_pc,
  input  logic [2:0]     if_flt,
  input  logic           id_illegal,
  input  logic           ex_arith,
  input  logic [2:0]     mem_flt,
  input  logic           rf_we_req,
  input  logic           mem_we_req,
  output logic           rf_we,
  output logic           mem_we,
  output logic           retire,
  output logic [PCW-1:0] retire_pc,
  output logic           exc_taken,
  output logic [3:0]     exc_cause,
  output logic [PCW-1:0] exc_pc
);
  localparam int NST   = 5;
  localparam int NFLAG = 8;
  localparam int WB    = NST - 1;
  localparam int MEM   = NST - 2;

  logic             vld [NST];
  logic [PCW-1:0]   pc  [NST];
  logic [NFLAG-1:0] vec [NST];
  logic [NFLAG-1:0] eff [NST];

  assign eff[0] = vld[0] ? (vec[0] | {5'b0, if_flt})              : '0;
  assign eff[1] = vld[1] ? (vec[1] | {4'b0, id_illegal, 3'b0})    : '0;
  assign eff[2] = vld[2] ? (vec[2] | {3'b0, ex_arith, 4'b0})      : '0;
  assign eff[3] = vld[3] ? (vec[3] | {mem_flt, 5'b0})             : '0;
  assign eff[4] = vld[4] ? vec[4] : '0;

  wire wb_bad   = |eff[WB];
  wire wb_fire  = vld[WB] && !stall;

  assign exc_taken = wb_fire && wb_bad;
  assign retire    = wb_fire && !wb_bad;
  assign retire_pc = pc[WB];
  assign exc_pc    = pc[WB];
  assign rf_we     = retire && rf_we_req;
  assign mem_we    = mem_we_req && vld[MEM] && !(|eff[MEM]) && !(vld[WB] && wb_bad);

  always_comb begin
    exc_cause = '0;
    if (exc_taken)
      for (int i = NFLAG - 1; i >= 0; i--)
        if (eff[WB][i]) exc_cause = 4'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || exc_taken) begin
      for (int k = 0; k < NST; k++) begin
        vld[k] <= 1'b0;
        vec[k] <= '0;
        if (!rst_n) pc[k] <= '0;
      end
    end else if (stall) begin
      for (int k = 0; k < NST; k++) vec[k] <= eff[k];
    end else begin
      vld[0] <= fetch_valid;
      pc[0]  <= fetch_pc;
      vec[0] <= '0;
      for (int k = 1; k < NST; k++) begin
        vld[k] <= vld[k-1];
        pc[k]  <= pc[k-1];
        vec[k] <= eff[k-1];
      end
    end
  end
endmodule

module pet_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stall,
  input logic       retire,
  input logic       exc_taken,
  input logic [3:0] exc_cause,
  input logic       rf_we,
  input logic       mem_we
);
  // R10
  exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) exc_taken |=> !exc_taken);
  // R6
  flush_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n) exc_taken |=> !retire);
  // R8
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) stall |-> !(retire || exc_taken));
  // R3
  cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> (exc_cause != 4'd0 && exc_cause <= 4'd8));
  // R7
  rf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) exc_taken |-> !rf_we);
  // R7
  mem_kill_chk: assert property (@(posedge clk) disable iff (!rst_n) exc_taken |-> !mem_we);
  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({retire, exc_taken}));
endmodule

bind precise_exc_tracker pet_checker u_pet_checker (
  .clk(clk), .rst_n(rst_n), .stall(stall), .retire(retire), .exc_taken(exc_taken),
  .exc_cause(exc_cause), .rf_we(rf_we), .mem_we(mem_we)
);

// File: tb/test_precise_exc_tracker.sv
module test_precise_exc_tracker;
  localparam int PCW = 32;
  logic clk = 1'b0, rst_n = 1'b0, stall, fetch_valid, id_illegal, ex_arith, rf_we_req, mem_we_req;
  logic [PCW-1:0] fetch_pc;
  logic [2:0] if_flt, mem_flt;
  logic rf_we, mem_we, retire, exc_taken;
  logic [PCW-1:0] retire_pc, exc_pc;
  logic [3:0] exc_cause;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  precise_exc_tracker #(.PCW(PCW)) i_precise_exc_tracker (.*);

  // {pc[15:0], stage[1:0], mask[2:0], expected code[3:0]}
  localparam int NT = 11;
  localparam logic [24:0] TBL [NT] = '{
    {16'h0100, 2'd0, 3'b001, 4'd1}, {16'h0104, 2'd0, 3'b010, 4'd2},
    {16'h0108, 2'd0, 3'b100, 4'd3}, {16'h010c, 2'd0, 3'b110, 4'd2},
    {16'h0110, 2'd1, 3'b001, 4'd4}, {16'h0114, 2'd2, 3'b001, 4'd5},
    {16'h0118, 2'd3, 3'b001, 4'd6}, {16'h011c, 2'd3, 3'b010, 4'd7},
    {16'h0120, 2'd3, 3'b100, 4'd8}, {16'h0124, 2'd3, 3'b101, 4'd6},
    {16'h0128, 2'd0, 3'b000, 4'd0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    stall = 0; fetch_valid = 0; fetch_pc = '0; if_flt = 0; id_illegal = 0;
    ex_arith = 0; mem_flt = 0; rf_we_req = 1; mem_we_req = 1;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic fetch(input logic [PCW-1:0] a);
    clr(); fetch_valid = 1; fetch_pc = a;
  endtask

  task automatic quiet(input string tag, input int n);
    for (int j = 0; j < n; j++) begin
      clr(); #1;
      chk(tag, {retire, exc_taken}, 2'b00);
      step();
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clr();
    @(negedge clk); step(); step();
    rst_n = 1;
    // R1: empty after reset
    #1;
    chk("R1 outputs", {retire, exc_taken, rf_we, mem_we}, 4'b0000);
    step();

    for (int i = 0; i < NT; i++) begin
      logic [15:0] a = TBL[i][24:9];
      logic [1:0]  st = TBL[i][8:7];
      logic [2:0]  m = TBL[i][6:4];
      logic [3:0]  code = TBL[i][3:0];
      string tag = (code == 0) ? "R2" : (m == 3'b110 || m == 3'b101) ? "R4" : "R3";
      fetch({16'h0, a}); step();
      for (int s = 0; s < 4; s++) begin
        clr();
        if (s == st) begin
          case (s)
            0: if_flt = m;
            1: id_illegal = m[0];
            2: ex_arith = m[0];
            default: mem_flt = m;
          endcase
        end
        #1;
        if (s == 3) chk({tag, " R7 mem_we"}, mem_we, code == 0);
        step();
      end
      clr(); #1;
      chk({tag, " exc_taken"}, exc_taken, code != 0);
      chk({tag, " retire"}, retire, code == 0);
      chk({tag, " cause"}, exc_cause, code);
      chk({tag, " pc"}, (code == 0) ? retire_pc : exc_pc, {16'h0, a});
      chk({tag, " R7 rf_we"}, rf_we, code == 0);
      step();
      clr(); #1;
      chk({tag, " R10 one cycle"}, {exc_taken, retire}, 2'b00);
      step();
    end

    // R4: faults from two stages on one instruction
    fetch(32'h200); step();
    clr(); if_flt = 3'b100; step();
    clr(); step(); clr(); step();
    clr(); mem_flt = 3'b001; step();
    clr(); #1;
    chk("R4 cross-stage cause", exc_cause, 4'd3);
    step();

    // R5: younger fault seen earlier, older reported first
    fetch(32'hA0); step();
    fetch(32'hB0); step();
    clr(); if_flt = 3'b001; step();
    clr(); step();
    clr(); mem_flt = 3'b001; ex_arith = 1; step();
    clr(); #1;
    chk("R5 older cause", exc_cause, 4'd6);
    chk("R5 older pc", exc_pc, 32'hA0);
    step();
    quiet("R5 younger dropped", 4);

    // R6 R7 R10: flush and memory kill
    fetch(32'hC0); step();
    fetch(32'hC4); step();
    fetch(32'hC8); clr(); id_illegal = 1; fetch_valid = 1; fetch_pc = 32'hC8; step();
    clr(); step(); clr(); step();
    clr(); #1;
    chk("R10 exc_taken", exc_taken, 1'b1);
    chk("R10 exc_pc", exc_pc, 32'hC0);
    chk("R7 mem kill by older fault", mem_we, 1'b0);
    step();
    quiet("R6 flushed", 5);

    // R8: stall accumulates and defers report
    fetch(32'hD0); step();
    clr(); stall = 1; if_flt = 3'b100; #1;
    chk("R8 quiet in stall", {retire, exc_taken}, 2'b00);
    step();
    clr(); step(); clr(); step(); clr(); step(); clr(); step();
    clr(); stall = 1; #1;
    chk("R8 report held", exc_taken, 1'b0);
    step();
    clr(); #1;
    chk("R8 report released", exc_taken, 1'b1);
    chk("R8 accumulated cause", exc_cause, 4'd3);
    chk("R8 pc", exc_pc, 32'hD0);
    step();

    // R9: faults on bubbles
    for (int j = 0; j < 7; j++) begin
      clr(); if_flt = 3'b111; id_illegal = 1; ex_arith = 1; mem_flt = 3'b111; #1;
      chk("R9 bubble silent", {retire, exc_taken, mem_we, rf_we}, 4'b0000);
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule